// File: doc/BRIEF.md
# Match-Interval Timer with Waveform Output

This block is one programmable timer channel. A 16-bit counter advances on cycles where an external count-enable tick is high. It can count up or down, and it runs in one of two modes. In free-running mode it wraps at the full counter range. In interval mode it wraps against a programmable interval value. Three match registers are compared with the count. Interval, match and overflow events set sticky status flags. An enable mask gates those flags onto a single interrupt line.

A waveform pin is driven from an internal state bit. A match-1 event sets that bit, and an interval or overflow wrap clears it. Its polarity can be inverted, and the pin can be forced low.

Software sees eight word registers through a plain read/write port. One 7-bit control register selects every mode, and also carries a self-clearing restart bit.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, the control register reads 0x21, the count reads 0, the wave pin is low and the irq pin is low.
- R2: While control bit 0 (disable) is high, the count holds its value.
- R3: When enabled, the count moves by one on each clock where tick is high and on no other clock. It counts up when control bit 2 is low and down when bit 2 is high.
- R4: With control bit 1 low (free-running mode), counting up from all-ones gives 0, and counting down from 0 gives all-ones. Each such wrap sets status bit 4 (overflow).
- R5: With control bit 1 high (interval mode), counting up from the interval value or above gives 0, and counting down from 0 reloads the interval value. Each such wrap sets status bit 0 (interval).
- R6: With control bit 3 high, an advance that lands the count on match register k (k = 1..3) sets status bit k. With bit 3 low, no match status is set.
- R7: Writing control with bit 4 high clears the count on that write, and bit 4 always reads back as 0.
- R8: Status bits are sticky. Reading the status address returns them and clears them, except that an event in the same cycle stays set.
- R9: irq is high exactly when some status bit is set whose bit in the interrupt enable register is also set.
- R10: The wave state is set by a match-1 event and cleared by an interval or overflow wrap; match 1 wins if both happen together. When control bit 5 is low, wave equals the state XOR control bit 6. When bit 5 is high, wave is low.
- R11: Register map by address: 0 control, 1 interval, 2/3/4 match 1/2/3, 5 interrupt enable, 6 status (read-to-clear), 7 count. Writes to addresses 6 and 7 are ignored. Unused high read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on address 6) |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, combinational from addr |
| irq | output | 1 | Masked interrupt |
| wave | output | 1 | Waveform output |

## Verification
The bench builds the timer with CNT_W = 8. This shrinks a full free-running cycle to 256 ticks, so both overflow wraps, up and down, are exercised directly. At this width a match-1 event can be followed through to the overflow that clears the waveform, and both polarities are checked in the same run. Interval wraps in both directions use a small interval of 9.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_MATCH = 3;
  localparam int ST_W      = NUM_MATCH + 2;
  localparam int ST_INTV   = 0;
  localparam int ST_OVF    = NUM_MATCH + 1;

  localparam int CTRL_W    = 7;
  localparam int C_DIS     = 0;
  localparam int C_INTV    = 1;
  localparam int C_DOWN    = 2;
  localparam int C_MATCH   = 3;
  localparam int C_RST     = 4;
  localparam int C_WAVE_N  = 5;
  localparam int C_POL     = 6;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 7'h21;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_INTV = 3'd1,
    A_M1   = 3'd2,
    A_M2   = 3'd3,
    A_M3   = 3'd4,
    A_IEN  = 3'd5,
    A_STAT = 3'd6,
    A_CNT  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         restart,
  input  logic         down,
  input  logic         intv_mode,
  input  logic [W-1:0] interval,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt_cnt,
  output logic         wrap_intv,
  output logic         wrap_ovf
);
  // Returns {wrapped, next_value} for one advance.
  function automatic logic [W:0] step_fn(input logic [W-1:0] c, input logic dn,
                                         input logic im, input logic [W-1:0] iv);
    logic [W:0] r;
    if (im && !dn)      r = (c >= iv) ? {1'b1, {W{1'b0}}} : {1'b0, c + 1'b1};
    else if (im && dn)  r = (c == '0) ? {1'b1, iv} : {1'b0, c - 1'b1};
    else if (!dn)       r = {1'b0, c} + 1'b1;
    else                r = (c == '0) ? {1'b1, {W{1'b1}}} : {1'b0, c - 1'b1};
    return r;
  endfunction

  logic [W:0] step;
  logic [W-1:0] cnt_q;

  always_comb begin
    step      = step_fn(cnt_q, down, intv_mode, interval);
    nxt_cnt   = step[W-1:0];
    wrap_intv = adv && intv_mode && step[W];
    wrap_ovf  = adv && !intv_mode && step[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (adv)     cnt_q <= nxt_cnt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic                adv,
  input  logic                enable,
  input  logic [W-1:0]        nxt_cnt,
  input  logic [N-1:0][W-1:0] match_val,
  output logic [N-1:0]        hit
);
  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit[k] = adv && enable && (nxt_cnt == match_val[k]);
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (clr ? '0 : st_q) | evt;
  end

  assign status = st_q;
  assign irq    = |(st_q & ien);
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic out_dis,
  input  logic pol,
  output logic wave
);
  logic state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= 1'b0;
    else if (set_evt) state_q <= 1'b1;
    else if (clr_evt) state_q <= 1'b0;
  end

  assign wave = !out_dis && (state_q ^ pol);
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq,
  output logic             wave
);
  logic [CTRL_W-1:0]                ctrl_q;
  logic [CNT_W-1:0]                 interval_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0]  match_q;
  logic [ST_W-1:0]                  ien_q;
  logic [ST_W-1:0]                  status;
  logic [ST_W-1:0]                  evt;
  logic [NUM_MATCH-1:0]             match_hit;
  logic [CNT_W-1:0]                 cnt, nxt_cnt;
  logic wr_ctrl, restart_req, adv, status_rd, any_evt, wrap_intv, wrap_ovf;

  assign wr_ctrl     = wr_en && (addr == A_CTRL);
  assign restart_req = wr_ctrl && wdata[C_RST];
  assign adv         = tick && !ctrl_q[C_DIS] && !restart_req;
  assign status_rd   = rd_en && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      interval_q <= '0;
      ien_q      <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          ctrl_q        <= wdata[CTRL_W-1:0];
          ctrl_q[C_RST] <= 1'b0;
        end
        A_INTV:  interval_q <= wdata;
        A_IEN:   ien_q      <= wdata[ST_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_mreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q[k] <= '0;
      else if (wr_en && (int'(addr) == int'(A_M1) + k)) match_q[k] <= wdata;
    end
    assign evt[1 + k] = match_hit[k];
  end

  assign evt[ST_INTV] = wrap_intv;
  assign evt[ST_OVF]  = wrap_ovf;
  assign any_evt      = |evt;

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .restart(restart_req),
    .down(ctrl_q[C_DOWN]), .intv_mode(ctrl_q[C_INTV]), .interval(interval_q),
    .cnt(cnt), .nxt_cnt(nxt_cnt), .wrap_intv(wrap_intv), .wrap_ovf(wrap_ovf)
  );

  tmr_match #(.W(CNT_W), .N(NUM_MATCH)) u_match (
    .adv(adv), .enable(ctrl_q[C_MATCH]), .nxt_cnt(nxt_cnt),
    .match_val(match_q), .hit(match_hit)
  );

  tmr_status #(.N(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(status_rd),
    .ien(ien_q), .status(status), .irq(irq)
  );

  tmr_wave u_wave (
    .clk(clk), .rst_n(rst_n), .set_evt(match_hit[0]),
    .clr_evt(wrap_intv || wrap_ovf), .out_dis(ctrl_q[C_WAVE_N]),
    .pol(ctrl_q[C_POL]), .wave(wave)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = CNT_W'(ctrl_q);
      A_INTV:  rdata = interval_q;
      A_M1:    rdata = match_q[0];
      A_M2:    rdata = match_q[1];
      A_M3:    rdata = match_q[2];
      A_IEN:   rdata = CNT_W'(ien_q);
      A_STAT:  rdata = CNT_W'(status);
      default: rdata = cnt;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              adv,
  input logic              restart,
  input logic              status_rd,
  input logic              any_evt,
  input logic [CTRL_W-1:0] ctrl,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      interval,
  input logic [ST_W-1:0]   status,
  input logic              wave
);
  assert_dis_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[C_DIS] && !restart) |=> (cnt == $past(cnt)));

  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> (cnt == $past(cnt)));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl[C_DOWN] && !ctrl[C_INTV] && (cnt != {W{1'b1}}))
      |=> (cnt == W'($past(cnt) + 1'b1)));

  assert_ovf_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl[C_INTV] && !ctrl[C_DOWN] && (cnt == {W{1'b1}}))
      |=> ((cnt == '0) && status[ST_OVF]));

  assert_intv_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ctrl[C_INTV] && ctrl[C_DOWN] && (cnt == '0))
      |=> ((cnt == $past(interval)) && status[ST_INTV]));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ((cnt == '0) && !ctrl[C_RST]));

  assert_status_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !any_evt) |=> (status == '0));

  assert_wave_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[C_WAVE_N] |-> !wave);
endmodule

bind tick_match_timer tmr_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .adv(adv), .restart(restart_req),
  .status_rd(status_rd), .any_evt(any_evt), .ctrl(ctrl_q), .cnt(cnt),
  .interval(interval_q), .status(status), .wave(wave)
);

// File: tb/tb_tick_match_timer.sv
module tb_tick_match_timer;
  localparam int W = 8;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq, wave;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [W-1:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  tick_match_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wave(wave)
  );

  // Monitor: compares each read against the expected item queued by the driver.
  always @(negedge clk) begin
    if (rd_en && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(posedge clk); #1 wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1 addr = a; rd_en = 1; sb_q.push_back(it);
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1 tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic pin(input logic got, input logic e, input string tag);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    pin(wave, 1'b0, "R1 wave at reset");
    pin(irq, 1'b0, "R1 irq at reset");
    rd(3'd0, 8'h21, "R1 ctrl reset");
    rd(3'd7, 8'h00, "R1 count reset");
    // R3 up counting, tick gating
    wr(3'd0, 8'h00);
    ticks(5);
    rd(3'd7, 8'd5, "R3 up by ticks");
    repeat (3) @(posedge clk);
    rd(3'd7, 8'd5, "R3 no tick no move");
    // R2 disable holds
    wr(3'd0, 8'h01);
    ticks(3);
    rd(3'd7, 8'd5, "R2 disabled hold");
    // R7 restart
    wr(3'd0, 8'h10);
    rd(3'd7, 8'd0, "R7 count cleared");
    rd(3'd0, 8'h00, "R7 bit self clear");
    // R4 overflow up, R9 irq
    wr(3'd5, 8'h10);
    ticks(256);
    rd(3'd7, 8'd0, "R4 up wrap");
    pin(irq, 1'b1, "R9 irq on enabled ovf");
    rd(3'd6, 8'h10, "R4 ovf status");
    rd(3'd6, 8'h00, "R8 status cleared by read");
    pin(irq, 1'b0, "R9 irq drops after clear");
    // R5 interval up
    wr(3'd1, 8'd9);
    wr(3'd0, 8'h12);
    ticks(10);
    rd(3'd7, 8'd0, "R5 up interval wrap");
    rd(3'd6, 8'h01, "R5 interval status");
    ticks(4);
    rd(3'd7, 8'd4, "R5 after wrap");
    // R5 interval down
    wr(3'd0, 8'h16);
    ticks(1);
    rd(3'd7, 8'd9, "R5 down reload");
    ticks(3);
    rd(3'd7, 8'd6, "R3 down count");
    rd(3'd6, 8'h01, "R5 down interval status");
    // R4 overflow down
    wr(3'd0, 8'h14);
    ticks(1);
    rd(3'd7, 8'hFF, "R4 down wrap");
    rd(3'd6, 8'h10, "R4 down ovf status");
    // R11 read-only addresses
    wr(3'd7, 8'h33);
    wr(3'd6, 8'hFF);
    rd(3'd7, 8'hFF, "R11 count write ignored");
    rd(3'd6, 8'h00, "R11 status write ignored");
    rd(3'd5, 8'h10, "R11 enable readback");
    // R6 matches, R10 wave
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd5);
    wr(3'd4, 8'd7);
    wr(3'd5, 8'h0E);
    wr(3'd0, 8'h18);
    pin(wave, 1'b0, "R10 wave idle pol0");
    ticks(3);
    #1 pin(wave, 1'b1, "R10 wave set by match1");
    pin(irq, 1'b1, "R9 irq on match1");
    wr(3'd0, 8'h28);
    pin(wave, 1'b0, "R10 wave forced low");
    wr(3'd0, 8'h08);
    pin(wave, 1'b1, "R10 wave restored");
    rd(3'd6, 8'h02, "R6 match1 status");
    ticks(2);
    rd(3'd6, 8'h04, "R6 match2 status");
    ticks(2);
    rd(3'd6, 8'h08, "R6 match3 status");
    ticks(249);
    #1 pin(wave, 1'b0, "R10 wave cleared by ovf");
    pin(irq, 1'b0, "R9 ovf masked");
    rd(3'd6, 8'h10, "R8 sticky ovf");
    // R10 inverted polarity
    wr(3'd0, 8'h58);
    pin(wave, 1'b1, "R10 idle pol1");
    ticks(3);
    #1 pin(wave, 1'b0, "R10 match1 pol1");
    rd(3'd6, 8'h02, "R6 match1 pol1");
    // R6 match mode off
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h10);
    pin(wave, 1'b1, "R10 state kept pol0");
    ticks(3);
    rd(3'd6, 8'h00, "R6 no match when off");
    ticks(253);
    #1 pin(irq, 1'b0, "R9 all masked");
    pin(wave, 1'b0, "R10 cleared by ovf");
    rd(3'd6, 8'h10, "R4 ovf with mask off");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule